// File: doc/BRIEF.md
# Charge Pump Start/Stop Sequencer

This controller decides when a dual-rail charge pump supply may run, brings its two regulators up in order, and takes the supply down again in a controlled way. It sees only digital flags from the analog side: a system enable, a supply-good indication, a flag that says the positive rail has passed its monitoring threshold, one overcurrent flag per rail, and a one-microsecond timebase tick. It drives registered enables back to the pump, the two regulators, the soft-start circuit and the clock selector, plus a latched fault flag.

Every interval is a count of timebase ticks, not of clock cycles, so the block runs on any system clock faster than the tick. A start needs the enable to have been seen low while the supply was good. The start opens a timed phase in which the pump runs on a fixed clock, and a longer window in which overcurrent flags are ignored. A short on either rail after that window shuts everything down until the enable is cycled. Dropping the enable does not cut the pump at once: the positive output is held for a while and the pump keeps running through a timed stop phase.

Top module: `cp_seq_ctrl`

## Requirements
- R1: During reset and after it, with no enable edge, all six outputs are low, and exactly one control state is active at every cycle.
- R2: A start needs the enable to have been low for at least one clock while supply_ok was high. If enable is already high when reset releases or when the supply becomes good, the block stays idle with all outputs low.
- R3: At the first clock edge after enable rises from the armed state, pump_run, pos_reg_en, startup_phase and softstart_on go high. startup_phase stays high until START_TICKS timebase ticks have been counted, then drops at the next edge. Cycles without a tick do not advance the count.
- R4: neg_reg_en goes high at the first edge where vpos_above is seen during start or run, and softstart_on drops at that same edge. Before that, neg_reg_en is low.
- R5: Overcurrent on either rail is ignored until MASK_TICKS ticks have elapsed since the start. After that, an overcurrent on oc_pos or oc_neg latches the fault at the next edge.
- R6: While the fault is latched, fault_latched is high and pump_run, pos_reg_en, neg_reg_en, softstart_on and startup_phase are low. It stays that way while enable is high. Enable low clears it at the next edge, and enable high afterwards starts again.
- R7: Enable low during start or run turns neg_reg_en off at the next edge. pos_reg_en is kept for HOLD_TICKS ticks, and pump_run for STOP_TICKS+1 ticks, and then all outputs are low. Enable going high again during the stop does not stop it or restart the supply; a new start needs enable low after the stop has ended.
- R8: supply_ok low forces the idle state at the next edge from any state, with all outputs low, including fault_latched. A later start needs a new enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | System enable, high to run |
| supply_ok | input | 1 | Input supply above its valid level |
| vpos_above | input | 1 | Positive rail above its monitoring threshold |
| oc_pos | input | 1 | Overcurrent on the positive rail |
| oc_neg | input | 1 | Overcurrent on the negative rail |
| tick_1us | input | 1 | One-cycle timebase tick, one per microsecond |
| pump_run | output | 1 | Charge pump running |
| pos_reg_en | output | 1 | Positive regulator enable |
| neg_reg_en | output | 1 | Negative regulator enable |
| softstart_on | output | 1 | Soft-start ramp active |
| startup_phase | output | 1 | Fixed-clock start phase, for the clock selector |
| fault_latched | output | 1 | Latched overcurrent shutdown |

## Verification
A wrong state shows on the outputs at the next clock edge, because every output is a registered decode of the next state and the next count. A state skipped or entered too soon makes pump_run, pos_reg_en or fault_latched differ for at least one cycle. A counter off by one tick moves the fall of startup_phase, the release of pos_reg_en or the first cycle a fault can latch by exactly one cycle. The checks are therefore placed at the last cycle before each boundary and the first cycle after it. A lost arming condition shows as a supply that starts while enable was never seen low.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [5:0] {
    ST_IDLE    = 6'b000001,
    ST_ARMED   = 6'b000010,
    ST_STARTUP = 6'b000100,
    ST_RUN     = 6'b001000,
    ST_STOP    = 6'b010000,
    ST_FAULT   = 6'b100000
  } seq_state_e;

  // Width needed to hold the largest of four tick limits plus one, so the
  // saturating counter can always exceed every limit.
  function automatic int unsigned span_bits(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return $clog2(m + 2);
  endfunction

  // True once a tick count has reached a limit.
  function automatic logic limit_hit(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/cps_tick_timer.sv
module cps_tick_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_n
);

  logic saturated;
  assign saturated = (cnt_q == {CW{1'b1}});

  always_comb begin
    if (restart)                cnt_n = '0;
    else if (tick && !saturated) cnt_n = cnt_q + CW'(1);
    else                        cnt_n = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/cps_seq_fsm.sv
module cps_seq_fsm
  import cps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       supply_ok,
  input  logic       oc_hit,
  input  logic       start_done,
  input  logic       stop_done,
  output seq_state_e state_q,
  output seq_state_e state_n,
  output logic       restart
);

  always_comb begin
    state_n = state_q;
    if (!supply_ok) begin
      state_n = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:    if (!en) state_n = ST_ARMED;
        ST_ARMED:   if (en)  state_n = ST_STARTUP;
        ST_STARTUP: begin
          if (oc_hit)          state_n = ST_FAULT;
          else if (!en)        state_n = ST_STOP;
          else if (start_done) state_n = ST_RUN;
        end
        ST_RUN: begin
          if (oc_hit)   state_n = ST_FAULT;
          else if (!en) state_n = ST_STOP;
        end
        ST_STOP:    if (stop_done) state_n = ST_IDLE;
        ST_FAULT:   if (!en) state_n = ST_IDLE;
        default:    state_n = ST_IDLE;
      endcase
    end
  end

  // The tick counter starts from zero on entry to either timed state.
  assign restart = (state_n != state_q) &&
                   ((state_n == ST_STARTUP) || (state_n == ST_STOP));

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

endmodule

// File: rtl/cps_out_stage.sv
module cps_out_stage
  import cps_pkg::*;
#(
  parameter int unsigned CW         = 16,
  parameter int unsigned HOLD_TICKS = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state_n,
  input  logic          restart,
  input  logic [CW-1:0] cnt_n,
  input  logic          vpos_above,
  output logic          pump_run,
  output logic          pos_reg_en,
  output logic          neg_reg_en,
  output logic          softstart_on,
  output logic          startup_phase,
  output logic          fault_latched
);

  logic powered_n, seen_q, seen_n, hold_n;

  assign powered_n = (state_n == ST_STARTUP) || (state_n == ST_RUN);
  assign seen_n    = ((restart ? 1'b0 : seen_q) | vpos_above) & powered_n;
  assign hold_n    = (state_n == ST_STOP) && !limit_hit(32'(cnt_n), HOLD_TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q        <= 1'b0;
      pump_run      <= 1'b0;
      pos_reg_en    <= 1'b0;
      neg_reg_en    <= 1'b0;
      softstart_on  <= 1'b0;
      startup_phase <= 1'b0;
      fault_latched <= 1'b0;
    end else begin
      seen_q        <= seen_n;
      pump_run      <= powered_n || (state_n == ST_STOP);
      pos_reg_en    <= powered_n || hold_n;
      neg_reg_en    <= seen_n;
      softstart_on  <= (state_n == ST_STARTUP) && !seen_n;
      startup_phase <= (state_n == ST_STARTUP);
      fault_latched <= (state_n == ST_FAULT);
    end
  end

endmodule

// File: rtl/cp_seq_ctrl.sv
module cp_seq_ctrl
  import cps_pkg::*;
#(
  parameter int unsigned MASK_TICKS  = 18000,
  parameter int unsigned START_TICKS = 9400,
  parameter int unsigned STOP_TICKS  = 7500,
  parameter int unsigned HOLD_TICKS  = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic supply_ok,
  input  logic vpos_above,
  input  logic oc_pos,
  input  logic oc_neg,
  input  logic tick_1us,
  output logic pump_run,
  output logic pos_reg_en,
  output logic neg_reg_en,
  output logic softstart_on,
  output logic startup_phase,
  output logic fault_latched
);

  localparam int unsigned CW = span_bits(MASK_TICKS, START_TICKS, STOP_TICKS, HOLD_TICKS);

  seq_state_e    state_q, state_n;
  logic          restart;
  logic [CW-1:0] cnt_q, cnt_n;

  // Named events, visible to the bound checker.
  logic oc_any, masked, oc_hit, start_done, stop_done;
  assign oc_any     = oc_pos | oc_neg;
  assign masked     = !limit_hit(32'(cnt_q), MASK_TICKS);
  assign oc_hit     = oc_any && !masked;
  assign start_done = limit_hit(32'(cnt_q), START_TICKS);
  assign stop_done  = limit_hit(32'(cnt_q), STOP_TICKS);

  cps_tick_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick_1us),
    .cnt_q(cnt_q), .cnt_n(cnt_n)
  );

  cps_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .supply_ok(supply_ok), .oc_hit(oc_hit),
    .start_done(start_done), .stop_done(stop_done),
    .state_q(state_q), .state_n(state_n), .restart(restart)
  );

  cps_out_stage #(.CW(CW), .HOLD_TICKS(HOLD_TICKS)) u_out (
    .clk(clk), .rst_n(rst_n), .state_n(state_n), .restart(restart), .cnt_n(cnt_n),
    .vpos_above(vpos_above),
    .pump_run(pump_run), .pos_reg_en(pos_reg_en), .neg_reg_en(neg_reg_en),
    .softstart_on(softstart_on), .startup_phase(startup_phase),
    .fault_latched(fault_latched)
  );

endmodule

// File: rtl/cps_seq_checker.sv
module cps_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       supply_ok,
  input logic [5:0] state,
  input logic       masked,
  input logic       pump_run,
  input logic       pos_reg_en,
  input logic       neg_reg_en,
  input logic       startup_phase,
  input logic       fault_latched
);

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1); // R1

  AST_PHASE_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
    startup_phase |-> (pump_run && pos_reg_en)); // R3

  AST_NEG_AFTER_POS: assert property (@(posedge clk) disable iff (!rst_n)
    neg_reg_en |-> pos_reg_en); // R4

  AST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> !$past(masked)); // R5

  AST_FAULT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> (!pump_run && !pos_reg_en && !neg_reg_en)); // R6

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && en && supply_ok) |=> fault_latched); // R6

  AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!pump_run && !fault_latched)); // R8

endmodule

bind cp_seq_ctrl cps_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .supply_ok(supply_ok),
  .state(state_q), .masked(masked),
  .pump_run(pump_run), .pos_reg_en(pos_reg_en), .neg_reg_en(neg_reg_en),
  .startup_phase(startup_phase), .fault_latched(fault_latched)
);

// File: tb/sim_cp_seq_ctrl.sv
`timescale 1ns/1ps
module sim_cp_seq_ctrl;

  localparam int MASK_T  = 20;
  localparam int START_T = 12;
  localparam int STOP_T  = 9;
  localparam int HOLD_T  = 5;

  logic clk = 1'b0;
  logic rst_n, en, supply_ok, vpos_above, oc_pos, oc_neg, tick;
  logic pump_run, pos_reg_en, neg_reg_en, softstart_on, startup_phase, fault_latched;
  int   vectors = 0, miscompares = 0, tick_div = 1, tick_ph = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  cp_seq_ctrl #(.MASK_TICKS(MASK_T), .START_TICKS(START_T),
                .STOP_TICKS(STOP_T), .HOLD_TICKS(HOLD_T)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .supply_ok(supply_ok), .vpos_above(vpos_above),
    .oc_pos(oc_pos), .oc_neg(oc_neg), .tick_1us(tick),
    .pump_run(pump_run), .pos_reg_en(pos_reg_en), .neg_reg_en(neg_reg_en),
    .softstart_on(softstart_on), .startup_phase(startup_phase),
    .fault_latched(fault_latched)
  );

  // Timebase: every cycle, or one cycle in tick_div.
  always @(negedge clk) begin
    if (tick_div <= 1) tick <= 1'b1;
    else begin
      tick    <= (tick_ph == 0);
      tick_ph <= (tick_ph + 1) % tick_div;
    end
  end

  // Bit order: {fault, startup_phase, softstart, neg, pos, pump}
  task automatic expect_outs(input string req, input logic [5:0] exp);
    logic [5:0] got;
    got = {fault_latched, startup_phase, softstart_on, neg_reg_en, pos_reg_en, pump_run};
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: outputs %b, expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: run incomplete, expected finish");
    finish_run();
  end

  initial begin
    rst_n = 0; en = 0; supply_ok = 1; vpos_above = 0; oc_pos = 0; oc_neg = 0; tick = 1;
    adv(5);
    expect_outs("R1 in reset", 6'b000000);
    rst_n = 1;
    adv(3);
    expect_outs("R1 idle after reset", 6'b000000);

    // R2: enable already high at reset release must not start
    rst_n = 0; en = 1;
    adv(3);
    rst_n = 1;
    adv(20);
    expect_outs("R2 enable high at release", 6'b000000);
    en = 0; adv(2);
    en = 1; adv(1);
    expect_outs("R3 start outputs", 6'b011011);
    adv(START_T);
    expect_outs("R3 last startup cycle", 6'b011011);
    adv(1);
    expect_outs("R3 startup phase ended", 6'b000011);

    // R5: overcurrent held from count 13; fault only once count reaches MASK_T
    oc_pos = 1;
    adv(MASK_T - START_T - 1);
    expect_outs("R5 still masked", 6'b000011);
    adv(1);
    expect_outs("R5 fault after mask", 6'b100000);
    oc_pos = 0;
    adv(10);
    expect_outs("R6 fault holds with enable high", 6'b100000);
    en = 0; adv(1);
    expect_outs("R6 fault cleared by enable low", 6'b000000);
    adv(1);
    en = 1; adv(1);
    expect_outs("R6 restart after clear", 6'b011011);

    // R4: negative regulator after positive rail threshold
    adv(3);
    expect_outs("R4 neg off before threshold", 6'b011011);
    vpos_above = 1; adv(1);
    expect_outs("R4 neg on, softstart off", 6'b010111);
    adv(9);
    expect_outs("R4 run with both rails", 6'b000111);
    oc_neg = 1; adv(1);
    oc_neg = 0; adv(1);
    expect_outs("R5 early negative overcurrent ignored", 6'b000111);
    adv(10);

    // R7: stop sequence
    en = 0; vpos_above = 0; adv(1);
    expect_outs("R7 stop entered, neg off", 6'b000011);
    en = 1;
    adv(HOLD_T - 1);
    expect_outs("R7 positive still held", 6'b000011);
    adv(1);
    expect_outs("R7 positive released", 6'b000001);
    adv(STOP_T - HOLD_T);
    expect_outs("R7 pump still running", 6'b000001);
    adv(1);
    expect_outs("R7 stop complete", 6'b000000);
    adv(10);
    expect_outs("R7 enable high during stop ignored", 6'b000000);
    en = 0; adv(2);
    en = 1; adv(1);
    expect_outs("R7 re-arm after stop", 6'b011011);

    // R8: supply loss
    supply_ok = 0; adv(1);
    expect_outs("R8 supply loss to idle", 6'b000000);
    supply_ok = 1; adv(15);
    expect_outs("R8 no start without new enable low", 6'b000000);
    en = 0; adv(2);

    // R3: interval counted in ticks, not cycles
    tick_div = 4;
    en = 1; adv(1);
    expect_outs("R3 sparse tick start", 6'b011011);
    adv(40);
    expect_outs("R3 sparse tick still in startup", 6'b011011);
    adv(20);
    expect_outs("R3 sparse tick startup ended", 6'b000011);

    finish_run();
  end

endmodule